// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a large set of peripheral request lines and the channels of a multi-channel transfer engine. Each request line has its own small programmable map register. The register names the target channel and carries a valid flag. Request lines are brought into the block clock domain through a synchronizer. For every channel, the block then selects the level of the request currently mapped to it and presents it as a registered per-channel request level.

From that routed level the block derives three event pulses for the channel status logic. A rise of the routed level means a request arrived while the channel could have been stopped, and it pulses a request-after-stop set. A fall means the peripheral ended its transfer early, and it pulses an end-of-receive event together with a request-after-stop clear. Software programs the map registers through a simple word-addressed register port. A write that would route a request to a channel that is not implemented is refused, and the refusal is flagged.

Top module: `dma_req_router`

## Requirements
- R1: After reset, `ch_req`, `ras_set`, `ras_clr`, `eor_evt`, `reg_err` and `reg_rvalid` are all zero, and every map register reads as zero, which means every map is invalid.
- R2: A map register keeps the channel number in bits 4:0 and the valid flag in bit 7. Bits 6:5 and all bits above bit 7 always read as zero. Read data appears with `reg_rvalid` one cycle after `reg_rd`.
- R3: Map register i for i < 64 sits at byte address 0x100 + 4*i. Map register i for 64 <= i < NUM_REQ sits at 0x1100 + 4*(i-64). A write to any other address, including a misaligned address, changes nothing. A read from such an address returns zero.
- R4: A request whose map register has the valid flag clear has no effect on any `ch_req`, `ras_set`, `ras_clr` or `eor_evt` bit.
- R5: `ch_req[c]` equals the level of the valid request mapped to channel c, SYNC_STAGES+1 cycles after the request input changes (3 cycles by default). It is 0 when no valid request maps to channel c.
- R6: When several valid requests map to one channel, the highest-numbered request alone decides the routed level.
- R7: In the cycle where `ch_req[c]` rises, `ras_set[c]` pulses for exactly one cycle. `ras_set` and `eor_evt` are never high together on one channel.
- R8: In the cycle where `ch_req[c]` falls, `eor_evt[c]` and `ras_clr[c]` pulse for exactly one cycle.
- R9: A write with bit 7 set and a channel number >= NUM_CH leaves the register unchanged and pulses `reg_err` one cycle later. A write with bit 7 clear is accepted whatever its channel field holds.
- R10: A map write that changes a channel's routed level has the same effect as a request change: the new level and its edge events appear two cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_REQ | Asynchronous peripheral request levels |
| reg_wr | input | 1 | Map register write strobe |
| reg_rd | input | 1 | Map register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| reg_err | output | 1 | Pulse: a valid map to an unimplemented channel was refused |
| ch_req | output | NUM_CH | Routed request level per channel |
| ras_set | output | NUM_CH | Pulse: routed request rose |
| ras_clr | output | NUM_CH | Pulse: routed request fell, clear request-after-stop |
| eor_evt | output | NUM_CH | Pulse: routed request fell, end of receive |

## Verification
The bench maps two requests to the same channel and toggles them one at a time. A design with the priority reversed would move the channel on the lower-numbered request instead. It reaches the upper address window and the addresses just past both windows. A decoder with wrong bounds would alias those addresses onto live registers. It remaps and invalidates requests while they are held high, so it can catch edges that are missed or doubled when the map itself moves the routed level. It also writes a valid map to an unimplemented channel and then reads the register back. A design that stores such a write would show the bad channel there and would route the request nowhere.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;
  localparam int CH_FIELD_W = 5;
  localparam int VLD_BIT    = 7;
  localparam int LOW_BASE   = 32'h0000_0100;
  localparam int HIGH_BASE  = 32'h0000_1100;
  localparam int LOW_MAX    = 64;

  typedef struct packed {
    logic                  vld;
    logic [CH_FIELD_W-1:0] ch;
  } map_ent_t;
endpackage

// File: rtl/dma_rr_sync.sv
module dma_rr_sync #(
  parameter int NUM_REQ     = 75,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_async,
  output logic [NUM_REQ-1:0] req_sync
);
  logic [SYNC_STAGES-1:0][NUM_REQ-1:0] stage_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= req_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign req_sync = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/dma_rr_mapregs.sv
module dma_rr_mapregs
  import dma_rr_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 32,
  localparam int IDX_W     = $clog2(NUM_REQ),
  localparam int LOW_SPAN  = (NUM_REQ < LOW_MAX) ? NUM_REQ : LOW_MAX,
  localparam int HIGH_SPAN = NUM_REQ - LOW_SPAN
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rvalid,
  output logic                      err,
  output map_ent_t [NUM_REQ-1:0]    map_o
);
  map_ent_t [NUM_REQ-1:0] map_q;
  logic [31:0]            a32;
  logic [31:0]            off;
  logic                   hit;
  logic [IDX_W-1:0]       idx;
  logic                   bad_ch;
  logic                   unused_bits;

  assign a32 = 32'(addr);

  // Two windows: low one from 0x100, high one from 0x1100.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    off = '0;
    if (a32[1:0] == 2'b00) begin
      if (a32 >= 32'(LOW_BASE) && a32 < 32'(LOW_BASE + 4*LOW_SPAN)) begin
        off = a32 - 32'(LOW_BASE);
        hit = 1'b1;
        idx = IDX_W'(off[31:2]);
      end else if (HIGH_SPAN > 0 && a32 >= 32'(HIGH_BASE) &&
                   a32 < 32'(HIGH_BASE + 4*HIGH_SPAN)) begin
        off = a32 - 32'(HIGH_BASE);
        hit = 1'b1;
        idx = IDX_W'(off[31:2] + 30'(LOW_SPAN));
      end
    end
  end

  assign bad_ch = wdata[VLD_BIT] &&
                  (32'(wdata[CH_FIELD_W-1:0]) >= 32'(NUM_CH));
  assign unused_bits = ^{wdata[DATA_W-1:8], wdata[6:5], off[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REQ; i++) map_q[i] <= '0;
      err <= 1'b0;
    end else begin
      err <= wr && hit && bad_ch;
      if (wr && hit && !bad_ch)
        map_q[idx] <= '{vld: wdata[VLD_BIT], ch: wdata[CH_FIELD_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd)
        rdata <= hit ? DATA_W'({map_q[idx].vld, 2'b00, map_q[idx].ch}) : '0;
    end
  end

  assign map_o = map_q;

  AST_ERR_KEEPS_MAP: assert property (@(posedge clk) disable iff (rst)
    err |-> $stable(map_q)); // R9
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid); // R2
  AST_RDATA_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata[6:5] == 2'b00 && rdata[DATA_W-1:8] == '0)); // R2

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
      AST_MAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        map_q[i].vld |-> (32'(map_q[i].ch) < 32'(NUM_CH))); // R9
    end
  endgenerate
endmodule

// File: rtl/dma_rr_router.sv
module dma_rr_router
  import dma_rr_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic [NUM_REQ-1:0]     req,
  input  map_ent_t [NUM_REQ-1:0] map_i,
  output logic [NUM_CH-1:0]      lvl
);
  // Ascending scan: a later (higher-numbered) hit overrides earlier ones.
  always_comb begin
    lvl = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (map_i[r].vld && map_i[r].ch == CH_FIELD_W'(c))
          lvl[c] = req[r];
      end
    end
  end
endmodule

// File: rtl/dma_rr_events.sv
module dma_rr_events #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] lvl,
  output logic [NUM_CH-1:0] ch_req,
  output logic [NUM_CH-1:0] ras_set,
  output logic [NUM_CH-1:0] ras_clr,
  output logic [NUM_CH-1:0] eor_evt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_req  <= '0;
      ras_set <= '0;
      ras_clr <= '0;
      eor_evt <= '0;
    end else begin
      ch_req  <= lvl;
      ras_set <= lvl & ~ch_req;
      ras_clr <= ~lvl & ch_req;
      eor_evt <= ~lvl & ch_req;
    end
  end

  AST_NO_RAS_AND_EOR: assert property (@(posedge clk) disable iff (rst)
    (ras_set & eor_evt) == '0); // R7

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      AST_RAS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        ras_set[c] |-> (ch_req[c] && !$past(ch_req[c]))); // R7
      AST_RISE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (ch_req[c] && !$past(ch_req[c])) |-> ras_set[c]); // R7
      AST_EOR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        eor_evt[c] |-> (!ch_req[c] && $past(ch_req[c]))); // R8
      AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!ch_req[c] && $past(ch_req[c])) |-> ras_clr[c]); // R8
    end
  endgenerate
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_rr_pkg::*;
#(
  parameter int NUM_REQ     = 75,
  parameter int NUM_CH      = 16,
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  output logic               reg_err,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_CH-1:0]  ras_set,
  output logic [NUM_CH-1:0]  ras_clr,
  output logic [NUM_CH-1:0]  eor_evt
);
  logic [NUM_REQ-1:0]     req_s;
  map_ent_t [NUM_REQ-1:0] map_w;
  logic [NUM_CH-1:0]      lvl_w;

  dma_rr_sync #(.NUM_REQ(NUM_REQ), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_async(req_in), .req_sync(req_s));

  dma_rr_mapregs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
                   .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .err(reg_err), .map_o(map_w));

  dma_rr_router #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .req(req_s), .map_i(map_w), .lvl(lvl_w));

  dma_rr_events #(.NUM_CH(NUM_CH)) u_evt (
    .clk(clk), .rst(rst), .lvl(lvl_w), .ch_req(ch_req),
    .ras_set(ras_set), .ras_clr(ras_clr), .eor_evt(eor_evt));
endmodule

// File: tb/tb_dma_req_router.sv
`timescale 1ns/1ps
module tb_dma_req_router;
  localparam int NREQ = 75;
  localparam int NCH  = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NREQ-1:0] req_in = '0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [12:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            reg_rvalid, reg_err;
  logic [NCH-1:0]  ch_req, ras_set, ras_clr, eor_evt;

  dma_req_router dut (
    .clk(clk), .rst(rst), .req_in(req_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .reg_err(reg_err), .ch_req(ch_req),
    .ras_set(ras_set), .ras_clr(ras_clr), .eor_evt(eor_evt));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int             due;
    logic [NCH-1:0] lvl, ras, eor;
    string          tag;
  } exp_t;
  exp_t q[$];
  exp_t item;

  bit             m_vld[NREQ];
  int             m_ch[NREQ];
  bit             m_req[NREQ];
  logic [NCH-1:0] prev_lvl = '0;

  function automatic logic [NCH-1:0] model_lvl();
    logic [NCH-1:0] v = '0;
    for (int r = 0; r < NREQ; r++)
      if (m_vld[r]) v[m_ch[r]] = m_req[r];
    return v;
  endfunction

  function automatic logic [12:0] addr_of(int i);
    return (i < 64) ? 13'(32'h100 + 4*i) : 13'(32'h1100 + 4*(i-64));
  endfunction

  task automatic push_exp(int due, string tag);
    logic [NCH-1:0] n = model_lvl();
    q.push_back('{due, n, n & ~prev_lvl, ~n & prev_lvl, tag});
    q.push_back('{due+1, n, '0, '0, {tag, " settle"}});
    prev_lvl = n;
  endtask

  // Monitor: compare the head item in its due cycle.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      if (q[0].due == cyc) begin
        item = q.pop_front();
        tests++;
        if (ch_req !== item.lvl || ras_set !== item.ras ||
            eor_evt !== item.eor || ras_clr !== item.eor) begin
          fails++;
          $display("FAIL %s: lvl=%h ras=%h eor=%h clr=%h exp lvl=%h ras=%h eor/clr=%h",
                   item.tag, ch_req, ras_set, eor_evt, ras_clr,
                   item.lvl, item.ras, item.eor);
        end
      end else if (q[0].due < cyc) begin
        item = q.pop_front();
        tests++; fails++;
        $display("FAIL %s: item overdue at %0d exp due %0d", item.tag, cyc, item.due);
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_req(int r, bit v, string tag);
    @(negedge clk);
    req_in[r] = v;
    m_req[r]  = v;
    push_exp(cyc + 3, tag);
    repeat (5) @(negedge clk);
  endtask

  task automatic wr_map(logic [12:0] a, logic [31:0] d, int idx, bit exp_err, string tag);
    int c;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; c = cyc;
    if (idx >= 0 && !exp_err) begin
      m_vld[idx] = d[7];
      m_ch[idx]  = int'(d[4:0]);
    end
    @(negedge clk);
    reg_wr = 1'b0;
    check(reg_err === exp_err, {tag, " err flag"}, 32'(reg_err), 32'(exp_err));
    push_exp(c + 2, tag);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_map(logic [12:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rvalid === 1'b1 && reg_rdata === e, tag, reg_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ch_req === '0 && ras_set === '0 && ras_clr === '0 && eor_evt === '0,
          "R1 outputs after reset", 32'(ch_req), 0);
    check(reg_err === 1'b0 && reg_rvalid === 1'b0, "R1 port flags after reset",
          32'({reg_err, reg_rvalid}), 0);
    rd_map(addr_of(0), 0, "R1 map 0 invalid");
    rd_map(addr_of(74), 0, "R1 map 74 invalid");

    set_req(5, 1, "R4 unmapped request high");
    set_req(5, 0, "R4 unmapped request low");

    wr_map(addr_of(5), 32'hE3, 5, 1'b0, "R2 map 5 to ch3");
    rd_map(addr_of(5), 32'h83, "R2 spare bits read zero");
    set_req(5, 1, "R5 R7 rise on ch3");
    set_req(5, 0, "R8 fall on ch3");

    wr_map(addr_of(70), 32'h8F, 70, 1'b0, "R3 high window map 70 to ch15");
    rd_map(addr_of(70), 32'h8F, "R3 high window readback");
    set_req(70, 1, "R3 R5 req 70 rise ch15");
    set_req(70, 0, "R3 R8 req 70 fall ch15");
    wr_map(13'h112C, 32'h81, -1, 1'b0, "R3 write past high window ignored");
    rd_map(13'h112C, 0, "R3 read past high window");
    rd_map(13'h00FC, 0, "R3 read below low window");
    rd_map(13'h0101, 0, "R3 misaligned read");

    wr_map(addr_of(10), 32'h82, 10, 1'b0, "R6 map 10 to ch2");
    wr_map(addr_of(20), 32'h82, 20, 1'b0, "R6 map 20 to ch2");
    set_req(10, 1, "R6 lower request alone no effect");
    set_req(20, 1, "R6 higher request rises ch2");
    set_req(10, 0, "R6 lower request drop no effect");
    set_req(20, 0, "R6 higher request falls ch2");

    set_req(10, 1, "R6 lower request high again");
    wr_map(addr_of(20), 32'h02, 20, 1'b0, "R10 invalidate 20, ch2 rises");
    wr_map(addr_of(10), 32'h84, 10, 1'b0, "R10 move 10 to ch4");

    wr_map(addr_of(10), 32'h90, 10, 1'b1, "R9 valid map to ch16 refused");
    rd_map(addr_of(10), 32'h84, "R9 register kept");
    wr_map(addr_of(10), 32'h1F, 10, 1'b0, "R9 invalid map with ch31 accepted");
    rd_map(addr_of(10), 32'h1F, "R9 invalid map readback");
    set_req(10, 0, "R4 invalid map request drop");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule